// File: doc/BRIEF.md
# Per-Source Interrupt Control and Dispatch

This block holds the interrupt settings of one peripheral and decides what happens when that peripheral raises its request line. Software programs an 8-bit control word through the write port. The word sets a priority level, a transfer-enable flag and a channel number. When the request is accepted, the block either starts a descriptor-driven data-transfer service or hands the event to the processor as an ordinary interrupt.

For the transfer path, the block also presents the address of the channel's descriptor. When the transfer service reports a non-zero termination status, the block clears the transfer-enable flag by itself. Later requests then fall back to the normal interrupt path.

Control word layout: bits [2:0] hold the level, bit [3] holds the transfer-enable flag, and bits [7:4] hold the channel. The level works as a priority: 0 is the most urgent, 6 is the least urgent, and 7 disables the source. A request is accepted only when the source level is strictly more urgent (numerically lower) than the processor's current level.

Top module: `irq_ctl_dispatch`

## Requirements
- R1: After reset, `rd_data` reads 0x07 (level 7, transfer-enable 0, channel 0), and `xfer_start`, `irq_start` and `desc_addr` are all zero.
- R2: A write on `wr_en` stores `wr_data` in full, and the new value shows on `rd_data` from the next cycle. `rd_data[7:4]` always reads 0 because the channel field is write-only. `rd_data[3]` is the enable flag and `rd_data[2:0]` is the level.
- R3: A pulse is issued one cycle after a clock edge only if, at that edge, `req` was 1, the level was not 7, and the level was numerically less than `cpu_lvl`. Equal or larger levels are not dispatched.
- R4: With level 7, no request ever produces `xfer_start` or `irq_start`.
- R5: An accepted request pulses `xfer_start` when the enable flag was 1 at the deciding edge, and pulses `irq_start` when it was 0. The two never pulse together.
- R6: While `xfer_start` is 1, `desc_addr` equals 0x000100 + 8 × channel, which spans 0x000100 to 0x000178. At all other times `desc_addr` is 0.
- R7: Each dispatch is a one-cycle pulse. While `req` stays high, no further dispatch happens until `req` has been low for at least one edge, or until `term_valid` has been seen.
- R8: `term_valid` with a non-zero `term_status` clears the enable flag. `term_valid` with `term_status` = 00 leaves the flag unchanged.
- R9: A software write in the same cycle as a termination clear takes priority, so the written enable value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write data |
| rd_data | output | 8 | Control word readback (channel bits read as 0) |
| req | input | 1 | Level-sensitive peripheral request |
| cpu_lvl | input | 3 | Current processor interrupt level |
| term_valid | input | 1 | Transfer service reports completion |
| term_status | input | 2 | Termination status; non-zero clears the enable flag |
| xfer_start | output | 1 | One-cycle pulse: start the transfer service |
| irq_start | output | 1 | One-cycle pulse: start the processor interrupt sequence |
| desc_addr | output | 24 | Descriptor address, valid with `xfer_start` |

## Verification
The bench drives requests with the level equal to, just above and just below the processor level, and with level 7. A design that compares with "less or equal", or that ignores the disable code, would emit a stray pulse.

Requests are held high across several cycles to catch a design that re-fires every cycle or never re-arms after a completion report. Channels 0, 3 and 15 expose a wrong address stride or base.

A termination status of 00 is paired with a non-zero one, and one non-zero report arrives in the same cycle as a software write. This shows whether the clear condition and the write priority are the right way round.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int LVL_W   = 3;
    localparam int CH_W    = 4;
    localparam int CSR_W   = LVL_W + 1 + CH_W;
    localparam int EN_BIT  = LVL_W;
    localparam logic [LVL_W-1:0] LVL_OFF = '1;

    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic             en;
        logic [LVL_W-1:0] lvl;
    } csr_t;

    typedef enum logic [1:0] {
        DSP_NONE = 2'd0,
        DSP_XFER = 2'd1,
        DSP_CPU  = 2'd2
    } dsp_e;

endpackage

// File: rtl/irq_csr.sv
module irq_csr
    import irq_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             term_valid,
    input  logic [1:0]       term_status,
    output logic [LVL_W-1:0] lvl,
    output logic             en,
    output logic [CH_W-1:0]  chan,
    output logic [CSR_W-1:0] rd_data
);

    csr_t csr_d, csr_q;

    always_comb begin
        csr_d = csr_q;
        if (term_valid && (term_status != 2'b00)) begin
            csr_d.en = 1'b0;
        end
        if (wr_en) begin
            csr_d = csr_t'(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q.lvl  <= LVL_OFF;
            csr_q.en   <= 1'b0;
            csr_q.chan <= '0;
        end else begin
            csr_q <= csr_d;
        end
    end

    assign lvl     = csr_q.lvl;
    assign en      = csr_q.en;
    assign chan    = csr_q.chan;
    assign rd_data = {{(CSR_W-1-EN_BIT){1'b0}}, csr_q.en, csr_q.lvl};

    AST_TERM_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (term_valid && (term_status != 2'b00) && !wr_en) |=> !en); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en == $past(wr_data[EN_BIT]))); // R9

endmodule

// File: rtl/irq_desc_addr.sv
module irq_desc_addr
    import irq_ctl_pkg::*;
#(
    parameter int                ADDR_W      = 24,
    parameter logic [ADDR_W-1:0] DESC_BASE   = 24'h000100,
    parameter int                STRIDE_LOG2 = 3
) (
    input  logic [CH_W-1:0]   chan,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = ADDR_W'(chan) << STRIDE_LOG2;
        addr   = DESC_BASE + offset;
    end

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_ctl_pkg::*;
#(
    parameter int                ADDR_W      = 24,
    parameter logic [ADDR_W-1:0] DESC_BASE   = 24'h000100,
    parameter int                STRIDE_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [LVL_W-1:0]  cpu_lvl,
    input  logic [LVL_W-1:0]  lvl,
    input  logic              en,
    input  logic              term_valid,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              xfer_start,
    output logic              irq_start,
    output logic [ADDR_W-1:0] desc_addr
);

    localparam logic [ADDR_W-1:0] ADDR_MAX =
        DESC_BASE + (ADDR_W'((1 << CH_W) - 1) << STRIDE_LOG2);

    typedef struct packed {
        logic              armed;
        dsp_e              kind;
        logic [ADDR_W-1:0] addr;
    } dsp_state_t;

    dsp_state_t st_d, st_q;
    logic       eligible;
    logic       fire;

    always_comb begin
        eligible   = req && (lvl != LVL_OFF) && (lvl < cpu_lvl);
        fire       = eligible && st_q.armed;
        st_d       = st_q;
        st_d.kind  = DSP_NONE;
        st_d.addr  = '0;
        if (fire) begin
            st_d.armed = 1'b0;
            if (en) begin
                st_d.kind = DSP_XFER;
                st_d.addr = addr_in;
            end else begin
                st_d.kind = DSP_CPU;
            end
        end else if (!req || term_valid) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.armed <= 1'b1;
            st_q.kind  <= DSP_NONE;
            st_q.addr  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xfer_start = (st_q.kind == DSP_XFER);
    assign irq_start  = (st_q.kind == DSP_CPU);
    assign desc_addr  = st_q.addr;

    AST_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start || irq_start) |-> $past(req)); // R3

    AST_LVL_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LVL_OFF) |=> !(xfer_start || irq_start)); // R4

    AST_XFER_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> $past(en)); // R5

    AST_CPU_NEEDS_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start |-> !$past(en)); // R5

    AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> ((desc_addr >= DESC_BASE) && (desc_addr <= ADDR_MAX))); // R6

    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start || irq_start) |=> !(xfer_start || irq_start)); // R7

endmodule

// File: rtl/irq_ctl_dispatch.sv
module irq_ctl_dispatch
    import irq_ctl_pkg::*;
#(
    parameter int                ADDR_W      = 24,
    parameter logic [ADDR_W-1:0] DESC_BASE   = 24'h000100,
    parameter int                STRIDE_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CSR_W-1:0]  wr_data,
    output logic [CSR_W-1:0]  rd_data,
    input  logic              req,
    input  logic [LVL_W-1:0]  cpu_lvl,
    input  logic              term_valid,
    input  logic [1:0]        term_status,
    output logic              xfer_start,
    output logic              irq_start,
    output logic [ADDR_W-1:0] desc_addr
);

    logic [LVL_W-1:0]  lvl;
    logic              en;
    logic [CH_W-1:0]   chan;
    logic [ADDR_W-1:0] chan_addr;

    irq_csr u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .term_valid  (term_valid),
        .term_status (term_status),
        .lvl         (lvl),
        .en          (en),
        .chan        (chan),
        .rd_data     (rd_data)
    );

    irq_desc_addr #(
        .ADDR_W      (ADDR_W),
        .DESC_BASE   (DESC_BASE),
        .STRIDE_LOG2 (STRIDE_LOG2)
    ) u_addr (
        .chan (chan),
        .addr (chan_addr)
    );

    irq_dispatch #(
        .ADDR_W      (ADDR_W),
        .DESC_BASE   (DESC_BASE),
        .STRIDE_LOG2 (STRIDE_LOG2)
    ) u_dsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .cpu_lvl    (cpu_lvl),
        .lvl        (lvl),
        .en         (en),
        .term_valid (term_valid),
        .addr_in    (chan_addr),
        .xfer_start (xfer_start),
        .irq_start  (irq_start),
        .desc_addr  (desc_addr)
    );

endmodule

// File: tb/irq_ctl_dispatch_bench.sv
module irq_ctl_dispatch_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        req = 1'b0;
    logic [2:0]  cpu_lvl = 3'd7;
    logic        term_valid = 1'b0;
    logic [1:0]  term_status = 2'b00;
    logic        xfer_start;
    logic        irq_start;
    logic [23:0] desc_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic        x;
        logic        i;
        logic [23:0] a;
        logic [7:0]  rd;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    irq_ctl_dispatch u_irq_ctl_dispatch (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .req         (req),
        .cpu_lvl     (cpu_lvl),
        .term_valid  (term_valid),
        .term_status (term_status),
        .xfer_start  (xfer_start),
        .irq_start   (irq_start),
        .desc_addr   (desc_addr)
    );

    task automatic step(input logic w, input logic [7:0] wd, input logic r,
                        input logic [2:0] cpu, input logic tv, input logic [1:0] ts,
                        input logic ex, input logic ei, input logic [23:0] ea,
                        input logic [7:0] erd, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en       = w;
        wr_data     = wd;
        req         = r;
        cpu_lvl     = cpu;
        term_valid  = tv;
        term_status = ts;
        e.x = ex; e.i = ei; e.a = ea; e.rd = erd; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #3;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                checks++;
                if (xfer_start !== e.x || irq_start !== e.i ||
                    desc_addr !== e.a || rd_data !== e.rd) begin
                    errors++;
                    $display("FAIL %s: got x=%b i=%b addr=%h rd=%h, expected x=%b i=%b addr=%h rd=%h",
                             e.tag, xfer_start, irq_start, desc_addr, rd_data,
                             e.x, e.i, e.a, e.rd);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        //    w  wdata  req cpu tv ts   x  i  addr        rd
        step(0, 8'h00, 0, 7, 0, 2'd0, 0, 0, 24'h000000, 8'h07, "R1 reset state");
        step(1, 8'hFA, 0, 7, 0, 2'd0, 0, 0, 24'h000000, 8'h0A, "R2 write lvl2 en chan15");
        step(0, 8'h00, 1, 7, 0, 2'd0, 1, 0, 24'h000178, 8'h0A, "R5 R6 transfer chan15");
        step(0, 8'h00, 1, 7, 0, 2'd0, 0, 0, 24'h000000, 8'h0A, "R7 held req no refire");
        step(0, 8'h00, 1, 7, 1, 2'd0, 0, 0, 24'h000000, 8'h0A, "R8 status 00 keeps enable");
        step(0, 8'h00, 1, 7, 0, 2'd0, 1, 0, 24'h000178, 8'h0A, "R7 rearm after termination");
        step(0, 8'h00, 0, 7, 0, 2'd0, 0, 0, 24'h000000, 8'h0A, "R7 release");
        step(0, 8'h00, 1, 2, 0, 2'd0, 0, 0, 24'h000000, 8'h0A, "R3 equal level blocked");
        step(0, 8'h00, 1, 3, 0, 2'd0, 1, 0, 24'h000178, 8'h0A, "R3 lower level dispatched");
        step(0, 8'h00, 0, 7, 1, 2'd1, 0, 0, 24'h000000, 8'h02, "R8 nonzero status clears");
        step(0, 8'h00, 1, 7, 0, 2'd0, 0, 1, 24'h000000, 8'h02, "R5 R6 cpu path addr zero");
        step(1, 8'h3B, 0, 7, 1, 2'd2, 0, 0, 24'h000000, 8'h0B, "R9 write beats clear");
        step(0, 8'h00, 1, 7, 0, 2'd0, 1, 0, 24'h000118, 8'h0B, "R6 chan3 address");
        step(1, 8'h0F, 0, 7, 0, 2'd0, 0, 0, 24'h000000, 8'h0F, "R2 write lvl7");
        step(0, 8'h00, 1, 7, 0, 2'd0, 0, 0, 24'h000000, 8'h0F, "R4 lvl7 silent");
        step(0, 8'h00, 0, 7, 0, 2'd0, 0, 0, 24'h000000, 8'h0F, "R4 lvl7 release");
        step(0, 8'h00, 1, 7, 0, 2'd0, 0, 0, 24'h000000, 8'h0F, "R4 lvl7 silent again");
        step(1, 8'h08, 0, 7, 0, 2'd0, 0, 0, 24'h000000, 8'h08, "R2 write lvl0 en chan0");
        step(0, 8'h00, 1, 7, 0, 2'd0, 1, 0, 24'h000100, 8'h08, "R6 chan0 base address");
        step(1, 8'h00, 0, 7, 0, 2'd0, 0, 0, 24'h000000, 8'h00, "R2 clear enable");
        step(0, 8'h00, 1, 1, 0, 2'd0, 0, 1, 24'h000000, 8'h00, "R3 lvl0 under cpu1");
        step(0, 8'h00, 1, 1, 0, 2'd0, 0, 0, 24'h000000, 8'h00, "R7 cpu pulse single");
        step(0, 8'h00, 0, 0, 0, 2'd0, 0, 0, 24'h000000, 8'h00, "R7 release again");
        step(0, 8'h00, 1, 0, 0, 2'd0, 0, 0, 24'h000000, 8'h00, "R3 cpu0 blocks all");
        @(negedge clk);
        req = 1'b0;
        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
        #4;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule